// File: doc/BRIEF.md
# Token-Passing Serial Readout Controller

This block is the readout sequencer that sits in every front-end chip of a daisy chain. All chips of the chain drive one shared serial data line, and a single token decides which chip may use it. A chip waits in idle until the token arrives on its token input. It then shifts its 8-bit chip identifier and its stored event words onto the line with a transmit-enable flag raised. After that it passes the token to its neighbour and drops back to idle, which is its low-power resting state. A chip that holds no events does not touch the line and hands the token on in the next cycle. The chain can be up to 100 chips long. The sequencing of each chip does not depend on the length of the chain.

The event store sits outside this block. The controller presents the index of the event being shifted and reads the matching word back in the same cycle. The number of stored events and the chip identifier are captured when the token is taken. The parameter `LAST_IN_CHAIN` picks the variant for the final chip: that chip raises a chain-complete pulse in place of a token output.

The states are `ST_IDLE` (waiting for the token), `ST_SEND_ID` (identifier bits), `ST_SEND_EVT` (event bits) and `ST_HANDOFF` (the single cycle that passes the token on). The transitions are as follows:
- idle→send-id on a token with a non-zero count.
- idle→handoff on a token with a zero count.
- send-id→send-evt after the last identifier bit.
- send-evt→send-evt between two events.
- send-evt→handoff after the last bit of the last event.
- handoff→idle unconditionally.

Top module: `rdo_token_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `ser_out`, `tx_on`, `token_out` and `chain_done` are 0. A reset during a readout abandons it and returns the block to idle.
- R2: `tx_on` is 1 exactly in the cycles in which a bit is driven. `ser_out` is 0 whenever `tx_on` is 0.
- R3: The serial order is the chip identifier first and then the events in index order 0, 1, 2 and so on. Every word goes most-significant bit first. The first identifier bit appears in the cycle after the token is sampled.
- R4: `token_out` is a one-cycle pulse in the cycle right after the last bit. A readout of N events therefore lasts 8 + N×EVT_W cycles plus one handoff cycle.
- R5: With an event count of 0, `token_out` pulses in the cycle after the token is sampled, and `tx_on` stays 0.
- R6: A token arriving while the block is sending or handing off is ignored. It produces no second readout and no extra `token_out` pulse.
- R7: `chip_id` and `evt_count` are captured at token acceptance. Changes made to them during the readout do not alter the bits sent or the readout length.
- R8: An `evt_count` above MAX_EVT is treated as MAX_EVT.
- R9: After the handoff cycle the block is idle. A token present in the cycle after handoff starts a new readout.
- R10: With `LAST_IN_CHAIN`=1, `token_out` stays 0 and `chain_done` pulses in the cycle where `token_out` would have pulsed. With `LAST_IN_CHAIN`=0, `chain_done` stays 0.
- R11: While the bits of event k are being shifted, `ev_index` equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| token_in | input | 1 | Readout token from the previous chip, sampled in idle |
| chip_id | input | ID_W (8) | Identifier of this chip, captured with the token |
| evt_count | input | CNT_W | Number of stored events, captured with the token |
| ev_word | input | EVT_W | Stored word at `ev_index`, returned in the same cycle |
| ev_index | output | IDX_W | Index of the event being shifted |
| ser_out | output | 1 | Serial data onto the shared line |
| tx_on | output | 1 | High while this chip drives the line |
| token_out | output | 1 | One-cycle token pulse to the next chip |
| chain_done | output | 1 | One-cycle end-of-chain pulse (last-chip variant only) |

## Verification
Two events can meet in the same cycle: a fresh token can arrive in the same cycle as the handoff pulse or the final data bit. A token can also arrive in the cycle right after the handoff, when the block has just become idle again. The bench provokes both by pulsing `token_in` during the handoff cycle and by holding `token_in` high across two whole readouts. A behavioural model built on a queue of the expected bits gives the reference. It decides acceptance from whether it was idle before the cycle, and it is compared against the outputs in every cycle. This shows that the late token is dropped and that the token in the idle cycle starts the next readout.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND_ID  = 2'd1,
        ST_SEND_EVT = 2'd2,
        ST_HANDOFF  = 2'd3
    } rdo_state_e;
endpackage

// File: rtl/rdo_bit_pick.sv
`timescale 1ns/1ps
// Selects one bit of a word by position.
module rdo_bit_pick #(
    parameter int W     = 16,
    parameter int SEL_W = 4
) (
    input  logic [W-1:0]     word,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (sel == SEL_W'(i)) bit_o = word[i];
        end
    end
endmodule

// File: rtl/rdo_pos_cnt.sv
`timescale 1ns/1ps
// Bit position (counting down) and event index (counting up).
module rdo_pos_cnt #(
    parameter int ID_W  = 8,
    parameter int EVT_W = 16,
    parameter int IDX_W = 4,
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             adv_evt,
    output logic [BIT_W-1:0] bit_pos,
    output logic [IDX_W-1:0] evt_idx,
    output logic             bit_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_pos <= '0;
            evt_idx <= '0;
        end else if (load) begin
            bit_pos <= BIT_W'(ID_W - 1);
            evt_idx <= '0;
        end else if (step) begin
            if (bit_pos == '0) begin
                bit_pos <= BIT_W'(EVT_W - 1);
                if (adv_evt) evt_idx <= evt_idx + 1'b1;
            end else begin
                bit_pos <= bit_pos - 1'b1;
            end
        end
    end

    assign bit_last = (bit_pos == '0);
endmodule

// File: rtl/rdo_token_ctrl.sv
`timescale 1ns/1ps
module rdo_token_ctrl #(
    parameter int ID_W          = 8,
    parameter int EVT_W         = 16,
    parameter int MAX_EVT       = 16,
    parameter bit LAST_IN_CHAIN = 1'b0,
    localparam int CNT_W        = $clog2(MAX_EVT + 1),
    localparam int IDX_W        = (MAX_EVT > 1) ? $clog2(MAX_EVT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             token_in,
    input  logic [ID_W-1:0]  chip_id,
    input  logic [CNT_W-1:0] evt_count,
    input  logic [EVT_W-1:0] ev_word,
    output logic [IDX_W-1:0] ev_index,
    output logic             ser_out,
    output logic             tx_on,
    output logic             token_out,
    output logic             chain_done
);
    import rdo_pkg::*;

    localparam int WMAX  = (ID_W > EVT_W) ? ID_W : EVT_W;
    localparam int BIT_W = (WMAX > 1) ? $clog2(WMAX) : 1;

    rdo_state_e       state_q, state_d;
    logic [ID_W-1:0]  id_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_sat;
    logic             accept;
    logic [BIT_W-1:0] bit_pos;
    logic [IDX_W-1:0] evt_idx;
    logic             bit_last;
    logic             last_evt;
    logic             id_bit;
    logic             ev_bit;
    logic             handoff;

    assign cnt_sat  = (evt_count > CNT_W'(MAX_EVT)) ? CNT_W'(MAX_EVT) : evt_count;
    assign accept   = (state_q == ST_IDLE) && token_in;
    assign last_evt = ((CNT_W'(evt_idx) + 1'b1) == cnt_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (token_in) state_d = (cnt_sat == '0) ? ST_HANDOFF : ST_SEND_ID;
            ST_SEND_ID:  if (bit_last) state_d = ST_SEND_EVT;
            ST_SEND_EVT: if (bit_last && last_evt) state_d = ST_HANDOFF;
            ST_HANDOFF:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and captured readout context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                id_q  <= chip_id;
                cnt_q <= cnt_sat;
            end
        end
    end

    rdo_pos_cnt #(
        .ID_W (ID_W),
        .EVT_W(EVT_W),
        .IDX_W(IDX_W),
        .BIT_W(BIT_W)
    ) pos_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (tx_on),
        .adv_evt (state_q == ST_SEND_EVT),
        .bit_pos (bit_pos),
        .evt_idx (evt_idx),
        .bit_last(bit_last)
    );

    rdo_bit_pick #(.W(ID_W),  .SEL_W(BIT_W)) id_pick_i (
        .word(id_q), .sel(bit_pos), .bit_o(id_bit)
    );
    rdo_bit_pick #(.W(EVT_W), .SEL_W(BIT_W)) ev_pick_i (
        .word(ev_word), .sel(bit_pos), .bit_o(ev_bit)
    );

    // Output decode
    always_comb begin
        tx_on   = 1'b0;
        ser_out = 1'b0;
        handoff = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_SEND_ID:  begin tx_on = 1'b1; ser_out = id_bit; end
            ST_SEND_EVT: begin tx_on = 1'b1; ser_out = ev_bit; end
            ST_HANDOFF:  handoff = 1'b1;
            default:     ;
        endcase
    end

    assign ev_index = evt_idx;

    generate
        if (LAST_IN_CHAIN) begin : g_last
            assign token_out  = 1'b0;
            assign chain_done = handoff;
        end else begin : g_mid
            assign token_out  = handoff;
            assign chain_done = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rdo_token_ctrl_chk.sv
`timescale 1ns/1ps
module rdo_token_ctrl_chk #(
    parameter int CNT_W         = 5,
    parameter bit LAST_IN_CHAIN = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                token_in,
    input logic [CNT_W-1:0]    evt_count,
    input logic                ser_out,
    input logic                tx_on,
    input logic                token_out,
    input logic                chain_done,
    input rdo_pkg::rdo_state_e state_q
);
    import rdo_pkg::*;

    logic pass_q;
    assign pass_q = token_out || chain_done;

    // R2
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> !ser_out);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |=> !pass_q);

    // R4
    pass_after_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |-> ($past(tx_on) || $past(state_q == ST_IDLE)));

    // R5
    empty_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && token_in && evt_count == '0) |=> (pass_q && !tx_on));

    // R9
    back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HANDOFF) |=> (state_q == ST_IDLE));

    // R10
    variant_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LAST_IN_CHAIN ? !token_out : !chain_done);
endmodule

bind rdo_token_ctrl rdo_token_ctrl_chk #(
    .CNT_W        (CNT_W),
    .LAST_IN_CHAIN(LAST_IN_CHAIN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .token_in  (token_in),
    .evt_count (evt_count),
    .ser_out   (ser_out),
    .tx_on     (tx_on),
    .token_out (token_out),
    .chain_done(chain_done),
    .state_q   (state_q)
);

// File: tb/rdo_token_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdo_token_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W    = 8;
    localparam int EVT_W   = 16;
    localparam int MAX_EVT = 16;
    localparam int CNT_W   = $clog2(MAX_EVT + 1);
    localparam int IDX_W   = $clog2(MAX_EVT);

    typedef struct packed {
        logic             chk;
        logic [IDX_W-1:0] idx;
        logic             tok;
        logic             tx;
        logic             ser;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic token_in = 1'b0;
    logic [ID_W-1:0]  chip_id = '0;
    logic [CNT_W-1:0] evt_count = '0;
    logic [EVT_W-1:0] mem [MAX_EVT];
    logic [IDX_W-1:0] ev_index, ev_index_l;
    logic ser_out, tx_on, token_out, chain_done;
    logic ser_l, tx_l, tok_l, done_l;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rdo_token_ctrl #(.ID_W(ID_W), .EVT_W(EVT_W), .MAX_EVT(MAX_EVT)) dut_i (
        .clk(clk), .rst_n(rst_n), .token_in(token_in), .chip_id(chip_id),
        .evt_count(evt_count), .ev_word(mem[ev_index]), .ev_index(ev_index),
        .ser_out(ser_out), .tx_on(tx_on), .token_out(token_out), .chain_done(chain_done)
    );

    rdo_token_ctrl #(.ID_W(ID_W), .EVT_W(EVT_W), .MAX_EVT(MAX_EVT), .LAST_IN_CHAIN(1'b1)) dut_last_i (
        .clk(clk), .rst_n(rst_n), .token_in(token_in), .chip_id(chip_id),
        .evt_count(evt_count), .ev_word(mem[ev_index_l]), .ev_index(ev_index_l),
        .ser_out(ser_l), .tx_on(tx_l), .token_out(tok_l), .chain_done(done_l)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model: queue of expected per-cycle outputs
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else begin
            bit was_idle;
            was_idle = (q.size() == 0);
            if (q.size() > 0) void'(q.pop_front());
            if (was_idle && token_in) begin
                int n;
                n = (int'(evt_count) > MAX_EVT) ? MAX_EVT : int'(evt_count);
                if (n != 0) begin
                    for (int b = ID_W - 1; b >= 0; b--)
                        q.push_back('{chk: 1'b0, idx: '0, tok: 1'b0, tx: 1'b1, ser: chip_id[b]});
                    for (int e = 0; e < n; e++)
                        for (int b = EVT_W - 1; b >= 0; b--)
                            q.push_back('{chk: 1'b1, idx: IDX_W'(e), tok: 1'b0, tx: 1'b1, ser: mem[e][b]});
                end
                q.push_back('{chk: 1'b0, idx: '0, tok: 1'b1, tx: 1'b0, ser: 1'b0});
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            exp_t x;
            x = (q.size() > 0) ? q[0] : '0;
            check(ser_out == x.ser, "R3 ser_out", ser_out, x.ser);
            check(tx_on == x.tx, "R2 tx_on", tx_on, x.tx);
            check(token_out == x.tok, "R4 token_out", token_out, x.tok);
            if (x.chk) check(ev_index == x.idx, "R11 ev_index", ev_index, x.idx);
            check(tok_l == 1'b0, "R10 last token_out", tok_l, 0);
            check(done_l == x.tok, "R10 last chain_done", done_l, x.tok);
            check(chain_done == 1'b0, "R10 mid chain_done", chain_done, 0);
        end
    end

    task automatic fill_mem(input int seed);
        for (int i = 0; i < MAX_EVT; i++)
            mem[i] = EVT_W'(seed * 40503 + i * 4099 + (i << 9));
    endtask

    // Pulses the token for one cycle and returns cycles until the pass pulse
    task automatic run_one(input logic [ID_W-1:0] id, input int cnt, output int len);
        @(negedge clk);
        chip_id = id;
        evt_count = CNT_W'(cnt);
        token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        len = 0;
        for (int k = 1; k < 400; k++) begin
            #1;
            if (token_out) begin len = k; break; end
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int len;
        int pulses;
        fill_mem(1);
        // R1: reset state
        idle_cycles(3);
        #1;
        check(!ser_out && !tx_on && !token_out && !chain_done, "R1 outputs in reset",
              {ser_out, tx_on, token_out, chain_done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!tx_on && !token_out, "R1 outputs after release", {tx_on, token_out}, 0);

        // R3 R4: three events
        fill_mem(7);
        run_one(8'hA5, 3, len);
        check(len == ID_W + 3 * EVT_W + 1, "R4 readout length 3 events", len, ID_W + 3 * EVT_W + 1);
        idle_cycles(2);

        // R5: zero events
        run_one(8'h3C, 0, len);
        check(len == 1, "R5 empty chip passes at once", len, 1);
        idle_cycles(2);

        // R3: single event with edge bit patterns
        mem[0] = 16'h8001;
        run_one(8'h81, 1, len);
        check(len == ID_W + EVT_W + 1, "R3 one event length", len, ID_W + EVT_W + 1);
        idle_cycles(2);

        // R8: count above maximum saturates
        fill_mem(3);
        run_one(8'h5A, 31, len);
        check(len == ID_W + MAX_EVT * EVT_W + 1, "R8 saturated length", len, ID_W + MAX_EVT * EVT_W + 1);
        idle_cycles(2);

        // R6 R7: token while busy, inputs changed mid-readout
        fill_mem(11);
        @(negedge clk);
        chip_id = 8'hC3; evt_count = CNT_W'(2); token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        pulses = 0;
        for (int k = 1; k < 60; k++) begin
            if (k == 5) begin token_in = 1'b1; chip_id = 8'h00; evt_count = CNT_W'(9); end
            if (k == 6) token_in = 1'b0;
            // token arrives in the handoff cycle (cycle 8+32+1)
            if (k == ID_W + 2 * EVT_W + 1) token_in = 1'b1;
            if (k == ID_W + 2 * EVT_W + 2) token_in = 1'b0;
            #1;
            if (token_out) pulses++;
            @(negedge clk);
        end
        check(pulses == 1, "R6 single pass despite busy tokens", pulses, 1);
        idle_cycles(2);

        // R9: token held high across consecutive readouts
        fill_mem(5);
        @(negedge clk);
        chip_id = 8'h66; evt_count = CNT_W'(1); token_in = 1'b1;
        pulses = 0;
        for (int k = 0; k < 2 * (ID_W + EVT_W + 2) + 1; k++) begin
            @(negedge clk);
            #1;
            if (token_out) pulses++;
        end
        token_in = 1'b0;
        check(pulses == 2, "R9 back-to-back readouts", pulses, 2);
        idle_cycles(ID_W + EVT_W + 4);

        // R1: reset in the middle of a readout
        @(negedge clk);
        chip_id = 8'h99; evt_count = CNT_W'(2); token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
        idle_cycles(10);
        rst_n = 1'b0;
        #1;
        check(!tx_on && !ser_out, "R1 reset aborts readout", {tx_on, ser_out}, 0);
        idle_cycles(2);
        rst_n = 1'b1;
        idle_cycles(3);
        #1;
        check(!tx_on && !token_out, "R1 idle after mid reset", {tx_on, token_out}, 0);
        run_one(8'h12, 2, len);
        check(len == ID_W + 2 * EVT_W + 1, "R9 readout after reset", len, ID_W + 2 * EVT_W + 1);
        idle_cycles(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule